// File: doc/BRIEF.md
# Data Address Translation Buffer with Access Checking

This block turns the effective address of a load or a store into a real address for 4 kB pages. It looks the page up in a small set-associative buffer of page table entries. It then applies the protection bits held in the entry to the kind of access and to the privilege level of the requester. The answer comes one clock after the request. It gives the real address, whether the access must bypass the cache, and one of four outcomes: a clean hit, a miss, a permission fault, or a cancellation.

A page walker outside the block fills entries through an install port. A separate invalidate port carries an operand word plus two selector fields. From these it either removes the one entry that maps a given page or empties the whole buffer. When translation is switched off for a request, the address passes straight through and no protection check is made.

If a request misses or faults, a request that arrives on the very next cycle is dropped. It is answered as cancelled so that the load/store pipeline can back off cleanly.

Top module: `dtlb_xlate`

## Requirements
- R1: After reset no entry is valid, and no response is signalled (rsp_valid low) until a request arrives.
- R2: The buffer has 64 sets of 2 ways, and the set is chosen by effective address bits 17:12. A translated request that hits answers one cycle later with rsp_hit=1 and rsp_ra = {stored real page number, ea[11:0]}.
- R3: With req_xlate=0 the response is rsp_hit=1, rsp_ra equal to the effective address, rsp_ci=0 and no fault, whatever the buffer holds and whatever the access type or privilege.
- R4: A translated request that matches no valid entry answers with rsp_miss=1 and rsp_hit=0. Exactly one of hit, miss and cancelled is set in every response.
- R5: A hit on an entry whose R bit is 0 raises rsp_perm_fault. A store hitting an entry whose C bit is 0 also raises rsp_perm_fault, while a load to that entry does not.
- R6: When authority bit 0 (ins_aa[0]) of the entry is 1, an access with req_pr=1 raises rsp_perm_fault, and the same access with req_pr=0 does not.
- R7: A store needs authority bit 2 (ins_aa[2]). A load needs authority bit 1 or bit 2. Without the needed bit, rsp_perm_fault is raised.
- R8: rsp_ci copies the entry's cache-inhibit attribute (ins_ci) on a hit that does not fault, and is 0 otherwise.
- R9: A request arriving in the cycle where a miss or permission fault is being answered is answered as rsp_cancelled=1, with no hit, miss or fault. The request after it is processed normally.
- R10: An invalidate with inv_rb[11:10]=0, inv_is=0 and inv_ap=0 clears only the valid entry whose page number equals inv_rb[63:12]. Other entries keep hitting.
- R11: An invalidate with inv_rb[10]=1, inv_rb[11]=1, a nonzero inv_is or a nonzero inv_ap clears every entry.
- R12: An install whose page already has an entry overwrites that way. Otherwise it fills an empty way, way 0 first. If both ways are full it replaces the way not used most recently, where both hits and installs count as use.
- R13: A request sees the buffer as it stood before any install or invalidate in the same cycle. When an invalidate and an install arrive together, the invalidate acts first and the installed entry survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ea | input | 64 | Effective address of the access |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_pr | input | 1 | Problem-state (unprivileged) access |
| req_xlate | input | 1 | Translation enabled for this access |
| ins_valid | input | 1 | Install an entry |
| ins_ea | input | 64 | Effective address of the page to install (bits 11:0 ignored) |
| ins_rpn | input | 52 | Real page number of the installed entry |
| ins_r | input | 1 | Referenced bit of the entry |
| ins_c | input | 1 | Changed bit of the entry |
| ins_aa | input | 3 | Access-authority bits of the entry |
| ins_ci | input | 1 | Cache-inhibit attribute of the entry |
| inv_valid | input | 1 | Invalidate request |
| inv_rb | input | 64 | Invalidate operand: page number in 63:12, flush selectors in 11:10 |
| inv_is | input | 2 | Invalidate scope field; nonzero flushes everything |
| inv_ap | input | 3 | Invalidate page-size field; nonzero flushes everything |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_ra | output | 64 | Real address (zero on miss or cancel) |
| rsp_hit | output | 1 | Entry found, or translation off |
| rsp_miss | output | 1 | No entry for the page |
| rsp_perm_fault | output | 1 | Entry found but access refused |
| rsp_ci | output | 1 | Access must bypass the cache |
| rsp_cancelled | output | 1 | Request dropped because the previous one failed |

## Verification
The lookup and the array update can fall in the same cycle. The bench provokes this by driving a request and an install for the same page on one clock edge, and then a flush together with an install. The request must report a miss, the following request must hit, and after the combined flush and install only the freshly installed page may hit. A second overlap, a failing response and a new request in the same cycle, is provoked with three back-to-back requests. The second must come back cancelled and the third must be honoured.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

  localparam int PAGE_BITS = 12;
  localparam int WAYS      = 2;

  typedef struct packed {
    logic       r;
    logic       c;
    logic [2:0] aa;
    logic       ci;
  } dtlb_perm_t;

  // Protection rule: referenced, changed for stores, privilege, read/write authority.
  function automatic logic perm_ok(dtlb_perm_t p, logic is_store, logic pr);
    logic ok;
    ok = p.r;
    if (is_store && !p.c)              ok = 1'b0;
    if (p.aa[0] && pr)                 ok = 1'b0;
    if (is_store && !p.aa[2])          ok = 1'b0;
    if (!is_store && !(p.aa[1] | p.aa[2])) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic inv_is_global(logic sel10, logic sel11,
                                         logic [1:0] is_f, logic [2:0] ap_f);
    return sel10 | sel11 | (|is_f) | (|ap_f);
  endfunction

endpackage

// File: rtl/dtlb_way.sv
module dtlb_way
  import dtlb_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int TAG_W = 46,
  parameter int RPN_W = 52,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic [RPN_W-1:0] rd_rpn,
  output dtlb_perm_t       rd_perm,
  input  logic [IDX_W-1:0] ins_idx,
  input  logic [TAG_W-1:0] ins_tag,
  output logic             ins_match,
  output logic             ins_free,
  input  logic             wr_en,
  input  logic [RPN_W-1:0] wr_rpn,
  input  dtlb_perm_t       wr_perm,
  input  logic             kill_en,
  input  logic [IDX_W-1:0] kill_idx,
  input  logic [TAG_W-1:0] kill_tag,
  input  logic             flush,
  output logic             any_valid
);

  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_q  [SETS];
  logic [RPN_W-1:0] rpn_q  [SETS];
  dtlb_perm_t       perm_q [SETS];

  assign rd_hit    = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_rpn    = rpn_q[rd_idx];
  assign rd_perm   = perm_q[rd_idx];
  assign ins_match = valid_q[ins_idx] && (tag_q[ins_idx] == ins_tag);
  assign ins_free  = !valid_q[ins_idx];
  assign any_valid = |valid_q;

  // Invalidate first, install last so a simultaneous install survives.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      if (flush)
        valid_q <= '0;
      else if (kill_en && valid_q[kill_idx] && (tag_q[kill_idx] == kill_tag))
        valid_q[kill_idx] <= 1'b0;
      if (wr_en)
        valid_q[ins_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[ins_idx]  <= ins_tag;
      rpn_q[ins_idx]  <= wr_rpn;
      perm_q[ins_idx] <= wr_perm;
    end
  end

endmodule

// File: rtl/dtlb_lru.sv
module dtlb_lru #(
  parameter int SETS = 64,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             touch_way,
  input  logic             ins_en,
  input  logic [IDX_W-1:0] ins_idx,
  input  logic             ins_way,
  output logic             victim
);

  // Each bit names the way to replace next in its set.
  logic [SETS-1:0] next_q;

  assign victim = next_q[ins_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_q <= '0;
    end else begin
      if (touch_en) next_q[touch_idx] <= ~touch_way;
      if (ins_en)   next_q[ins_idx]   <= ~ins_way;
    end
  end

endmodule

// File: rtl/dtlb_xlate.sv
module dtlb_xlate
  import dtlb_pkg::*;
#(
  parameter int EA_W = 64,
  parameter int SETS = 64,
  localparam int IDX_W = $clog2(SETS),
  localparam int RPN_W = EA_W - PAGE_BITS,
  localparam int TAG_W = EA_W - PAGE_BITS - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [EA_W-1:0]  req_ea,
  input  logic             req_store,
  input  logic             req_pr,
  input  logic             req_xlate,
  input  logic             ins_valid,
  input  logic [EA_W-1:0]  ins_ea,
  input  logic [RPN_W-1:0] ins_rpn,
  input  logic             ins_r,
  input  logic             ins_c,
  input  logic [2:0]       ins_aa,
  input  logic             ins_ci,
  input  logic             inv_valid,
  input  logic [EA_W-1:0]  inv_rb,
  input  logic [1:0]       inv_is,
  input  logic [2:0]       inv_ap,
  output logic             rsp_valid,
  output logic [EA_W-1:0]  rsp_ra,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_perm_fault,
  output logic             rsp_ci,
  output logic             rsp_cancelled
);

  logic [IDX_W-1:0] req_idx, ins_idx, inv_idx;
  logic [TAG_W-1:0] req_tag, ins_tag, inv_tag;

  assign req_idx = req_ea[PAGE_BITS +: IDX_W];
  assign req_tag = req_ea[EA_W-1 -: TAG_W];
  assign ins_idx = ins_ea[PAGE_BITS +: IDX_W];
  assign ins_tag = ins_ea[EA_W-1 -: TAG_W];
  assign inv_idx = inv_rb[PAGE_BITS +: IDX_W];
  assign inv_tag = inv_rb[EA_W-1 -: TAG_W];

  logic unused_low;
  assign unused_low = ^{ins_ea[PAGE_BITS-1:0], inv_rb[9:0]};

  // Named internal events, used by the checker.
  logic flush_req, kill_req, cancel_now, go, any_valid;
  assign flush_req  = inv_valid && inv_is_global(inv_rb[10], inv_rb[11], inv_is, inv_ap);
  assign kill_req   = inv_valid && !flush_req;
  assign cancel_now = req_valid && rsp_valid && (rsp_miss || rsp_perm_fault);
  assign go         = req_valid && !cancel_now;

  dtlb_perm_t ins_perm;
  assign ins_perm = '{r: ins_r, c: ins_c, aa: ins_aa, ci: ins_ci};

  logic [WAYS-1:0]  hit_vec, match_vec, free_vec, wr_vec, valid_vec;
  logic [RPN_W-1:0] way_rpn  [WAYS];
  dtlb_perm_t       way_perm [WAYS];
  logic             lru_victim;
  logic             ins_way;

  // Overwrite a matching way, else fill an empty way, else replace the LRU way.
  always_comb begin
    if (match_vec[0])      ins_way = 1'b0;
    else if (match_vec[1]) ins_way = 1'b1;
    else if (free_vec[0])  ins_way = 1'b0;
    else if (free_vec[1])  ins_way = 1'b1;
    else                   ins_way = lru_victim;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign wr_vec[w] = ins_valid && (ins_way == w[0]);
    dtlb_way #(.SETS(SETS), .TAG_W(TAG_W), .RPN_W(RPN_W)) u_way (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (req_idx),
      .rd_tag    (req_tag),
      .rd_hit    (hit_vec[w]),
      .rd_rpn    (way_rpn[w]),
      .rd_perm   (way_perm[w]),
      .ins_idx   (ins_idx),
      .ins_tag   (ins_tag),
      .ins_match (match_vec[w]),
      .ins_free  (free_vec[w]),
      .wr_en     (wr_vec[w]),
      .wr_rpn    (ins_rpn),
      .wr_perm   (ins_perm),
      .kill_en   (kill_req),
      .kill_idx  (inv_idx),
      .kill_tag  (inv_tag),
      .flush     (flush_req),
      .any_valid (valid_vec[w])
    );
  end

  assign any_valid = |valid_vec;

  logic             hit_any;
  logic [RPN_W-1:0] sel_rpn;
  dtlb_perm_t       sel_perm;
  always_comb begin
    sel_rpn  = '0;
    sel_perm = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        sel_rpn  = sel_rpn  | way_rpn[w];
        sel_perm = sel_perm | way_perm[w];
      end
    end
  end
  assign hit_any = |hit_vec;

  logic access_ok;
  assign access_ok = perm_ok(sel_perm, req_store, req_pr);

  dtlb_lru #(.SETS(SETS)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (go && req_xlate && hit_any),
    .touch_idx (req_idx),
    .touch_way (hit_vec[1]),
    .ins_en    (ins_valid),
    .ins_idx   (ins_idx),
    .ins_way   (ins_way),
    .victim    (lru_victim)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_ra         <= '0;
      rsp_hit        <= 1'b0;
      rsp_miss       <= 1'b0;
      rsp_perm_fault <= 1'b0;
      rsp_ci         <= 1'b0;
      rsp_cancelled  <= 1'b0;
    end else begin
      rsp_valid      <= req_valid;
      rsp_cancelled  <= cancel_now;
      rsp_hit        <= go && (!req_xlate || hit_any);
      rsp_miss       <= go && req_xlate && !hit_any;
      rsp_perm_fault <= go && req_xlate && hit_any && !access_ok;
      rsp_ci         <= go && req_xlate && hit_any && access_ok && sel_perm.ci;
      if (!go)             rsp_ra <= '0;
      else if (!req_xlate) rsp_ra <= req_ea;
      else if (hit_any)    rsp_ra <= {sel_rpn, req_ea[PAGE_BITS-1:0]};
      else                 rsp_ra <= '0;
    end
  end

endmodule

// File: rtl/dtlb_checker.sv
module dtlb_checker #(
  parameter int EA_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [EA_W-1:0] req_ea,
  input logic            req_xlate,
  input logic            ins_valid,
  input logic            flush_req,
  input logic            cancel_now,
  input logic            any_valid,
  input logic            rsp_valid,
  input logic [EA_W-1:0] rsp_ra,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic            rsp_perm_fault,
  input logic            rsp_ci,
  input logic            rsp_cancelled
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_perm_fault || rsp_ci || rsp_cancelled));

  assert_passthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_xlate && !cancel_now) |=>
      (rsp_hit && !rsp_perm_fault && !rsp_ci && rsp_ra == $past(req_ea)));

  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_cancelled}) == 1));

  assert_fault_needs_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_perm_fault |-> rsp_hit);

  assert_ci_clean_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ci |-> (rsp_hit && !rsp_perm_fault));

  assert_cancel_follows_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_valid && (rsp_miss || rsp_perm_fault)) |=>
      (rsp_cancelled && !rsp_hit && !rsp_miss && !rsp_perm_fault));

  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !ins_valid) |=> !any_valid);

endmodule

bind dtlb_xlate dtlb_checker #(.EA_W(EA_W)) u_dtlb_checker (.*);

// File: tb/tb_dtlb_xlate.sv
`timescale 1ns/1ps
module tb_dtlb_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_store = 0, req_pr = 0, req_xlate = 0;
  logic [63:0] req_ea = '0;
  logic        ins_valid = 0, ins_r = 0, ins_c = 0, ins_ci = 0;
  logic [63:0] ins_ea = '0;
  logic [51:0] ins_rpn = '0;
  logic [2:0]  ins_aa = '0;
  logic        inv_valid = 0;
  logic [63:0] inv_rb = '0;
  logic [1:0]  inv_is = '0;
  logic [2:0]  inv_ap = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_perm_fault, rsp_ci, rsp_cancelled;
  logic [63:0] rsp_ra;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dtlb_xlate dut (.*);

  function automatic logic [63:0] page(logic [45:0] tag, logic [5:0] set, logic [11:0] off);
    return {tag, set, off};
  endfunction

  task automatic expect_rsp(string req, logic hit, logic miss, logic pf, logic ci,
                            logic canc, logic [63:0] ra, logic cmp_ra);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_hit !== hit || rsp_miss !== miss || rsp_perm_fault !== pf ||
        rsp_ci !== ci || rsp_cancelled !== canc || (cmp_ra && rsp_ra !== ra)) begin
      errors++;
      $display("FAIL %s: actual v%b h%b m%b pf%b ci%b c%b ra=%h expected v1 h%b m%b pf%b ci%b c%b ra=%h",
               req, rsp_valid, rsp_hit, rsp_miss, rsp_perm_fault, rsp_ci, rsp_cancelled, rsp_ra,
               hit, miss, pf, ci, canc, ra);
    end
  endtask

  task automatic lookup(logic [63:0] ea, logic st, logic pr, logic xl);
    @(negedge clk);
    req_valid = 1; req_ea = ea; req_store = st; req_pr = pr; req_xlate = xl;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic install(logic [63:0] ea, logic [51:0] rpn, logic r, logic c,
                         logic [2:0] aa, logic ci);
    @(negedge clk);
    ins_valid = 1; ins_ea = ea; ins_rpn = rpn; ins_r = r; ins_c = c; ins_aa = aa; ins_ci = ci;
    @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic invalidate(logic [63:0] rb, logic [1:0] is_f, logic [2:0] ap_f);
    @(negedge clk);
    inv_valid = 1; inv_rb = rb; inv_is = is_f; inv_ap = ap_f;
    @(negedge clk);
    inv_valid = 0;
  endtask

  // Pages used below: tag, set index (ea[17:12]).
  localparam logic [63:0] PA = {46'd1, 6'd3, 12'h0};
  localparam logic [63:0] PB = {46'd2, 6'd4, 12'h0};
  localparam logic [63:0] PC = {46'd3, 6'd6, 12'h0};
  localparam logic [63:0] PD = {46'd4, 6'd7, 12'h0};
  localparam logic [63:0] PE = {46'd5, 6'd8, 12'h0};
  localparam logic [63:0] PF = {46'd6, 6'd9, 12'h0};
  localparam logic [63:0] PG = {46'd7, 6'd10, 12'h0};
  localparam logic [63:0] PH = {46'd8, 6'd11, 12'h0};

  task automatic t_reset();
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++; $display("FAIL R1 reset: actual rsp_valid=%b expected 0", rsp_valid);
    end
    lookup(PA | 64'h10, 0, 0, 1);
    expect_rsp("R1 empty after reset", 0, 1, 0, 0, 0, 64'h0, 1);
  endtask

  task automatic t_passthrough();
    lookup(64'h1234_5678_9abc_def0, 0, 0, 0);
    expect_rsp("R3 load real mode", 1, 0, 0, 0, 0, 64'h1234_5678_9abc_def0, 1);
    lookup(64'hfedc_ba98_7654_3210, 1, 1, 0);
    expect_rsp("R3 store pr real mode", 1, 0, 0, 0, 0, 64'hfedc_ba98_7654_3210, 1);
  endtask

  task automatic t_basic();
    install(PA, 52'hABC, 1, 1, 3'b110, 0);
    lookup(PA | 64'h123, 0, 0, 1);
    expect_rsp("R2 load hit", 1, 0, 0, 0, 0, 64'hABC123, 1);
    lookup(PA | 64'hFFF, 1, 1, 1);
    expect_rsp("R2 store hit", 1, 0, 0, 0, 0, 64'hABCFFF, 1);
    lookup(page(46'd9, 6'd3, 12'h0), 0, 0, 1);
    expect_rsp("R4 same set other tag miss", 0, 1, 0, 0, 0, 64'h0, 1);
    lookup(PA, 0, 0, 0);
    expect_rsp("R3 real mode ignores entry", 1, 0, 0, 0, 0, PA, 1);
  endtask

  task automatic t_perm();
    install(PB, 52'h200, 0, 1, 3'b110, 0);
    lookup(PB, 0, 0, 1);
    expect_rsp("R5 R=0 load", 1, 0, 1, 0, 0, 64'h0, 0);
    install(PC, 52'h300, 1, 0, 3'b110, 0);
    lookup(PC, 1, 0, 1);
    expect_rsp("R5 C=0 store", 1, 0, 1, 0, 0, 64'h0, 0);
    lookup(PC | 64'h4, 0, 0, 1);
    expect_rsp("R5 C=0 load", 1, 0, 0, 0, 0, 64'h300004, 1);
    install(PD, 52'h400, 1, 1, 3'b111, 0);
    lookup(PD, 0, 1, 1);
    expect_rsp("R6 aa0 problem state", 1, 0, 1, 0, 0, 64'h0, 0);
    lookup(PD, 1, 0, 1);
    expect_rsp("R6 aa0 privileged", 1, 0, 0, 0, 0, 64'h400000, 1);
    install(PE, 52'h500, 1, 1, 3'b010, 0);
    lookup(PE, 0, 1, 1);
    expect_rsp("R7 aa1 load", 1, 0, 0, 0, 0, 64'h500000, 1);
    lookup(PE, 1, 0, 1);
    expect_rsp("R7 aa1 store", 1, 0, 1, 0, 0, 64'h0, 0);
    install(PF, 52'h600, 1, 1, 3'b100, 0);
    lookup(PF, 0, 0, 1);
    expect_rsp("R7 aa2 load", 1, 0, 0, 0, 0, 64'h600000, 1);
    lookup(PF, 1, 0, 1);
    expect_rsp("R7 aa2 store", 1, 0, 0, 0, 0, 64'h600000, 1);
    install(PG, 52'h700, 1, 1, 3'b000, 0);
    lookup(PG, 0, 0, 1);
    expect_rsp("R7 no authority load", 1, 0, 1, 0, 0, 64'h0, 0);
  endtask

  task automatic t_ci();
    install(PH, 52'h800, 1, 1, 3'b110, 1);
    lookup(PH | 64'h8, 0, 0, 1);
    expect_rsp("R8 inhibited hit", 1, 0, 0, 1, 0, 64'h800008, 1);
    lookup(PH, 0, 0, 0);
    expect_rsp("R8 real mode not inhibited", 1, 0, 0, 0, 0, PH, 1);
    install(PH, 52'h800, 0, 1, 3'b110, 1);
    lookup(PH, 0, 0, 1);
    expect_rsp("R8 faulting access not inhibited", 1, 0, 1, 0, 0, 64'h0, 0);
  endtask

  task automatic t_cancel();
    @(negedge clk);
    req_valid = 1; req_ea = page(46'd77, 6'd30, 12'h0); req_store = 0; req_pr = 0; req_xlate = 1;
    @(negedge clk);
    expect_rsp("R9 first miss", 0, 1, 0, 0, 0, 64'h0, 1);
    req_ea = PA | 64'h5;
    @(negedge clk);
    expect_rsp("R9 follower cancelled", 0, 0, 0, 0, 1, 64'h0, 1);
    @(negedge clk);
    expect_rsp("R9 next honoured", 1, 0, 0, 0, 0, 64'hABC005, 1);
    req_valid = 0;
    // Permission fault followed at once by a real-mode request.
    @(negedge clk);
    req_valid = 1; req_ea = PB; req_xlate = 1;
    @(negedge clk);
    expect_rsp("R9 perm fault", 1, 0, 1, 0, 0, 64'h0, 0);
    req_ea = 64'h42; req_xlate = 0;
    @(negedge clk);
    expect_rsp("R9 cancel after perm fault", 0, 0, 0, 0, 1, 64'h0, 1);
    req_valid = 0;
  endtask

  task automatic t_inval_single();
    invalidate(page(46'd3, 6'd6, 12'h0) ^ 64'h1000_0000_0000_0000, 0, 0);
    lookup(PC, 0, 0, 1);
    expect_rsp("R10 wrong tag leaves entry", 1, 0, 0, 0, 0, 64'h300000, 1);
    invalidate(PA | 64'h1FF, 0, 0);
    lookup(PA, 0, 0, 1);
    expect_rsp("R10 target removed", 0, 1, 0, 0, 0, 64'h0, 1);
    lookup(PC, 0, 0, 1);
    expect_rsp("R10 other entry kept", 1, 0, 0, 0, 0, 64'h300000, 1);
  endtask

  task automatic t_flush();
    install(PA, 52'hABC, 1, 1, 3'b110, 0);
    invalidate(64'h400, 0, 0);
    lookup(PA, 0, 0, 1);
    expect_rsp("R11 flush by bit 10", 0, 1, 0, 0, 0, 64'h0, 1);
    lookup(PE, 0, 0, 1);
    expect_rsp("R11 bit 10 clears others", 0, 1, 0, 0, 0, 64'h0, 1);
    install(PA, 52'hABC, 1, 1, 3'b110, 0);
    invalidate(64'h800, 0, 0);
    lookup(PA, 0, 0, 1);
    expect_rsp("R11 flush by bit 11", 0, 1, 0, 0, 0, 64'h0, 1);
    install(PA, 52'hABC, 1, 1, 3'b110, 0);
    invalidate(page(46'd500, 6'd50, 12'h0), 2'd1, 0);
    lookup(PA, 0, 0, 1);
    expect_rsp("R11 flush by scope field", 0, 1, 0, 0, 0, 64'h0, 1);
    install(PA, 52'hABC, 1, 1, 3'b110, 0);
    invalidate(page(46'd500, 6'd50, 12'h0), 0, 3'd2);
    lookup(PA, 0, 0, 1);
    expect_rsp("R11 flush by size field", 0, 1, 0, 0, 0, 64'h0, 1);
  endtask

  task automatic t_lru();
    logic [63:0] p1, p2, p3;
    p1 = page(46'h11, 6'd20, 12'h0);
    p2 = page(46'h12, 6'd20, 12'h0);
    p3 = page(46'h13, 6'd20, 12'h0);
    install(p1, 52'h11, 1, 1, 3'b110, 0);
    install(p2, 52'h12, 1, 1, 3'b110, 0);
    lookup(p1, 0, 0, 1);
    expect_rsp("R12 first way hit", 1, 0, 0, 0, 0, 64'h11000, 1);
    install(p3, 52'h13, 1, 1, 3'b110, 0);
    lookup(p2, 0, 0, 1);
    expect_rsp("R12 unused way evicted", 0, 1, 0, 0, 0, 64'h0, 1);
    lookup(p1, 0, 0, 1);
    expect_rsp("R12 recent way kept", 1, 0, 0, 0, 0, 64'h11000, 1);
    lookup(p3, 0, 0, 1);
    expect_rsp("R12 new entry present", 1, 0, 0, 0, 0, 64'h13000, 1);
    install(p3, 52'h33, 1, 1, 3'b110, 0);
    lookup(p3, 0, 0, 1);
    expect_rsp("R12 overwrite same page", 1, 0, 0, 0, 0, 64'h33000, 1);
    lookup(p1, 0, 0, 1);
    expect_rsp("R12 overwrite kept neighbour", 1, 0, 0, 0, 0, 64'h11000, 1);
  endtask

  task automatic t_same_cycle();
    logic [63:0] q, z;
    q = page(46'h21, 6'd40, 12'h0);
    z = page(46'h22, 6'd41, 12'h0);
    @(negedge clk);
    ins_valid = 1; ins_ea = q; ins_rpn = 52'h21; ins_r = 1; ins_c = 1; ins_aa = 3'b110; ins_ci = 0;
    req_valid = 1; req_ea = q; req_store = 0; req_pr = 0; req_xlate = 1;
    @(negedge clk);
    ins_valid = 0; req_valid = 0;
    expect_rsp("R13 request sees old state", 0, 1, 0, 0, 0, 64'h0, 1);
    lookup(q, 0, 0, 1);
    expect_rsp("R13 install visible next", 1, 0, 0, 0, 0, 64'h21000, 1);
    @(negedge clk);
    inv_valid = 1; inv_rb = 64'h400; inv_is = 0; inv_ap = 0;
    ins_valid = 1; ins_ea = z; ins_rpn = 52'h22;
    @(negedge clk);
    inv_valid = 0; ins_valid = 0;
    lookup(z, 0, 0, 1);
    expect_rsp("R13 install survives flush", 1, 0, 0, 0, 0, 64'h22000, 1);
    lookup(q, 0, 0, 1);
    expect_rsp("R13 flush removed older", 0, 1, 0, 0, 0, 64'h0, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual run hung, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_passthrough();
    t_basic();
    t_perm();
    t_ci();
    t_cancel();
    t_inval_single();
    t_flush();
    t_lru();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule